// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This block decides whether a relative branch of an 8-bit processor is taken, and it computes the address where execution continues. A four-bit condition selector picks one of sixteen tests. Each test is evaluated against the low nibble of the condition-code register.

The unit also adds either a sign-extended short displacement or a full-width long displacement to the program counter. That program counter value is the address just past the displacement bytes. The unit reports a fixed base cycle cost for the instruction.

The instruction sequencer drives the inputs whenever a branch reaches the execute stage. It picks up the registered decision one clock later. Pushing a return address and fetching instructions are left to neighbouring logic.

Top module: `branch_decide`

## Requirements
- R1: While rst_n is low, and after it is released until the first evaluation, taken, next_pc and cycles are all zero.
- R2: Selector 0x0 is always taken. Selector 0x1 is never taken, but still reports the full cycle cost and the fall-through address.
- R3: Single-flag tests use these condition-code bits: carry bit 0, overflow bit 1, zero bit 2, negative bit 3. The selectors are 0x4 (carry clear), 0x5 (carry set), 0x6 (zero clear), 0x7 (zero set), 0x8 (overflow clear), 0x9 (overflow set), 0xA (negative clear) and 0xB (negative set).
- R4: Selector 0x2 (unsigned higher) is taken when carry and zero are both clear. Selector 0x3 (unsigned lower-or-same) is taken when carry or zero is set.
- R5: Selector 0xC is taken when negative equals overflow. Selector 0xD is taken when they differ.
- R6: Selector 0xE is taken when zero is clear and negative equals overflow. Selector 0xF is taken when zero is set or negative differs from overflow.
- R7: When long_form is 0, the taken target is pc_after plus disp[7:0] sign-extended, modulo 2^16. disp[15:8] has no effect.
- R8: When long_form is 1, the taken target is pc_after plus disp[15:0], modulo 2^16.
- R9: When the branch is not taken, next_pc equals pc_after.
- R10: cycles is 3 for the short form and 5 for the long form, whether or not the branch is taken.
- R11: ccr bits 7..4 have no effect on the decision.
- R12: Every output reflects the inputs sampled at the preceding rising clock edge, and at no earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_sel | input | 4 | Branch condition selector (opcode low nibble) |
| long_form | input | 1 | 1 selects the 16-bit displacement form |
| ccr | input | 8 | Condition-code register |
| pc_after | input | 16 | Program counter just past the displacement bytes |
| disp | input | 16 | Raw displacement; the short form uses bits 7..0 |
| taken | output | 1 | Branch decision |
| next_pc | output | 16 | Target address if taken, else pc_after |
| cycles | output | 4 | Base cycle cost of the branch |

## Verification
All three results come out of one register stage, so each is due exactly one rising edge after its inputs are presented. The bench drives new inputs on a falling edge and compares the outputs on the following falling edge, which is half a period after the capturing edge. For the latency requirement, the bench first samples the outputs before the capturing edge, to confirm that they still hold the previous result. It then samples them after that edge to confirm the new result.

// File: rtl/branch_decide_pkg.sv
package branch_decide_pkg;
   // Condition-code bit positions the decision depends on
   localparam int unsigned CC_CARRY = 0;
   localparam int unsigned CC_OVFL  = 1;
   localparam int unsigned CC_ZERO  = 2;
   localparam int unsigned CC_NEG   = 3;

   // Selector encoding; odd codes are the complement of their even partner
   typedef enum logic [3:0] {
      SEL_ALWAYS = 4'h0, SEL_NEVER = 4'h1,
      SEL_HI     = 4'h2, SEL_LS    = 4'h3,
      SEL_CCLR   = 4'h4, SEL_CSET  = 4'h5,
      SEL_ZCLR   = 4'h6, SEL_ZSET  = 4'h7,
      SEL_VCLR   = 4'h8, SEL_VSET  = 4'h9,
      SEL_NCLR   = 4'hA, SEL_NSET  = 4'hB,
      SEL_GE     = 4'hC, SEL_LT    = 4'hD,
      SEL_GT     = 4'hE, SEL_LE    = 4'hF
   } cond_sel_e;

   typedef struct packed {
      logic neg;
      logic zero;
      logic ovfl;
      logic carry;
   } cc_flags_t;
endpackage

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
   import branch_decide_pkg::*;
#(
   parameter bit PAIR_FOLD = 1'b1   // 1: evaluate 8 bases then invert by bit 0
)(
   input  logic [3:0] sel,
   input  cc_flags_t  flg,
   output logic       take
);
   logic n_xor_v;
   assign n_xor_v = flg.neg ^ flg.ovfl;

   generate
      if (PAIR_FOLD) begin : g_fold
         logic base;
         always_comb begin
            unique case (sel[3:1])
               3'd0: base = 1'b1;
               3'd1: base = ~(flg.carry | flg.zero);
               3'd2: base = ~flg.carry;
               3'd3: base = ~flg.zero;
               3'd4: base = ~flg.ovfl;
               3'd5: base = ~flg.neg;
               3'd6: base = ~n_xor_v;
               default: base = ~(flg.zero | n_xor_v);
            endcase
         end
         assign take = base ^ sel[0];
      end else begin : g_flat
         always_comb begin
            unique case (cond_sel_e'(sel))
               SEL_ALWAYS: take = 1'b1;
               SEL_NEVER:  take = 1'b0;
               SEL_HI:     take = ~flg.carry & ~flg.zero;
               SEL_LS:     take = flg.carry | flg.zero;
               SEL_CCLR:   take = ~flg.carry;
               SEL_CSET:   take = flg.carry;
               SEL_ZCLR:   take = ~flg.zero;
               SEL_ZSET:   take = flg.zero;
               SEL_VCLR:   take = ~flg.ovfl;
               SEL_VSET:   take = flg.ovfl;
               SEL_NCLR:   take = ~flg.neg;
               SEL_NSET:   take = flg.neg;
               SEL_GE:     take = ~n_xor_v;
               SEL_LT:     take = n_xor_v;
               SEL_GT:     take = ~flg.zero & ~n_xor_v;
               default:    take = flg.zero | n_xor_v;
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/branch_target_calc.sv
module branch_target_calc #(
   parameter int unsigned PC_W    = 16,
   parameter int unsigned SHORT_W = 8,
   parameter int unsigned LONG_W  = 16
)(
   input  logic [PC_W-1:0]   base_pc,
   input  logic [LONG_W-1:0] raw_disp,
   input  logic              use_long,
   output logic [PC_W-1:0]   target
);
   localparam int unsigned SEXT_S = PC_W - SHORT_W;

   logic [PC_W-1:0] short_ext;
   logic [PC_W-1:0] long_ext;

   assign short_ext = {{SEXT_S{raw_disp[SHORT_W-1]}}, raw_disp[SHORT_W-1:0]};

   generate
      if (LONG_W < PC_W) begin : g_long_sext
         assign long_ext = {{(PC_W-LONG_W){raw_disp[LONG_W-1]}}, raw_disp};
      end else begin : g_long_full
         assign long_ext = raw_disp[PC_W-1:0];
      end
   endgenerate

   // Modular add: carry out of the top bit is dropped
   assign target = base_pc + (use_long ? long_ext : short_ext);
endmodule

// File: rtl/branch_decide.sv
module branch_decide
   import branch_decide_pkg::*;
#(
   parameter int unsigned PC_W      = 16,
   parameter int unsigned SHORT_W   = 8,
   parameter int unsigned LONG_W    = 16,
   parameter int unsigned CYC_W     = 4,
   parameter int unsigned SHORT_CYC = 3,
   parameter int unsigned LONG_CYC  = 5,
   parameter bit          PAIR_FOLD = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        cond_sel,
   input  logic              long_form,
   input  logic [7:0]        ccr,
   input  logic [PC_W-1:0]   pc_after,
   input  logic [LONG_W-1:0] disp,
   output logic              taken,
   output logic [PC_W-1:0]   next_pc,
   output logic [CYC_W-1:0]  cycles
);
   localparam logic [CYC_W-1:0] CYC_S = CYC_W'(SHORT_CYC);
   localparam logic [CYC_W-1:0] CYC_L = CYC_W'(LONG_CYC);

   generate
      if (SHORT_W >= PC_W || SHORT_W > LONG_W || SHORT_W < 2)
         $error("branch_decide: SHORT_W must be >=2, < PC_W and <= LONG_W");
      if (LONG_W > PC_W)
         $error("branch_decide: LONG_W must not exceed PC_W");
      if (SHORT_CYC >= (1 << CYC_W) || LONG_CYC >= (1 << CYC_W))
         $error("branch_decide: cycle costs do not fit CYC_W");
   endgenerate

   cc_flags_t       flg;
   logic            take_c;
   logic [PC_W-1:0] tgt_c;

   // Only the low nibble of the condition codes takes part
   assign flg = cc_flags_t'({ccr[CC_NEG], ccr[CC_ZERO], ccr[CC_OVFL], ccr[CC_CARRY]});

   branch_cond_eval #(.PAIR_FOLD(PAIR_FOLD)) u_cond (
      .sel  (cond_sel),
      .flg  (flg),
      .take (take_c)
   );

   branch_target_calc #(.PC_W(PC_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_tgt (
      .base_pc  (pc_after),
      .raw_disp (disp),
      .use_long (long_form),
      .target   (tgt_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taken   <= 1'b0;
         next_pc <= '0;
         cycles  <= '0;
      end else begin
         taken   <= take_c;
         next_pc <= take_c ? tgt_c : pc_after;
         cycles  <= long_form ? CYC_L : CYC_S;
      end
   end

   // Marks cycles whose previous edge loaded the output register
   logic primed;
   always_ff @(posedge clk) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!taken && next_pc == '0 && cycles == '0)); // R1
   AST_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(cond_sel) == 4'h1) |-> !taken); // R2
   AST_ALWAYS_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(cond_sel) == 4'h0) |-> taken); // R2
   AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !taken) |-> next_pc == $past(pc_after)); // R9
   AST_FIXED_COST: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> cycles == ($past(long_form) ? CYC_L : CYC_S)); // R10
   AST_PAIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(cond_sel) == 4'hC && $past(ccr[CC_NEG]) != $past(ccr[CC_OVFL])) |-> !taken); // R5
endmodule

// File: tb/branch_decide_bench.sv
module branch_decide_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cond_sel = '0;
   logic        long_form = 1'b0;
   logic [7:0]  ccr = '0;
   logic [15:0] pc_after = '0;
   logic [15:0] disp = '0;
   logic        taken;
   logic [15:0] next_pc;
   logic [3:0]  cycles;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   branch_decide u_branch_decide (
      .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel), .long_form(long_form),
      .ccr(ccr), .pc_after(pc_after), .disp(disp),
      .taken(taken), .next_pc(next_pc), .cycles(cycles)
   );

   // {sel, long, ccr, pc_after, disp, exp_taken, exp_next_pc, exp_cycles}
   localparam int NV = 25;
   localparam logic [65:0] VEC [NV] = '{
      {4'h0, 1'b0, 8'h00, 16'h1000, 16'h0010, 1'b1, 16'h1010, 4'd3}, // R2
      {4'h1, 1'b0, 8'hFF, 16'h1000, 16'h0010, 1'b0, 16'h1000, 4'd3}, // R2 R9
      {4'h1, 1'b1, 8'h00, 16'h2000, 16'h0100, 1'b0, 16'h2000, 4'd5}, // R2 R10
      {4'h2, 1'b0, 8'h00, 16'h1000, 16'h0005, 1'b1, 16'h1005, 4'd3}, // R4
      {4'h2, 1'b0, 8'h04, 16'h1000, 16'h0005, 1'b0, 16'h1000, 4'd3}, // R4
      {4'h3, 1'b0, 8'h01, 16'h1000, 16'h00FE, 1'b1, 16'h0FFE, 4'd3}, // R4 R7
      {4'h3, 1'b0, 8'h00, 16'h1000, 16'h00FE, 1'b0, 16'h1000, 4'd3}, // R4
      {4'h4, 1'b0, 8'h02, 16'h1000, 16'h0010, 1'b1, 16'h1010, 4'd3}, // R3
      {4'h5, 1'b0, 8'h01, 16'h1000, 16'h0010, 1'b1, 16'h1010, 4'd3}, // R3
      {4'h6, 1'b0, 8'h04, 16'h1000, 16'h0010, 1'b0, 16'h1000, 4'd3}, // R3
      {4'h7, 1'b0, 8'h04, 16'h1000, 16'hAB80, 1'b1, 16'h0F80, 4'd3}, // R3 R7
      {4'h8, 1'b0, 8'h02, 16'h1000, 16'h0010, 1'b0, 16'h1000, 4'd3}, // R3
      {4'h9, 1'b1, 8'h02, 16'h1000, 16'h1234, 1'b1, 16'h2234, 4'd5}, // R3 R8
      {4'hA, 1'b0, 8'h08, 16'h1000, 16'h0010, 1'b0, 16'h1000, 4'd3}, // R3
      {4'hB, 1'b1, 8'h08, 16'h2000, 16'hF000, 1'b1, 16'h1000, 4'd5}, // R3 R8
      {4'hC, 1'b0, 8'h0A, 16'h1000, 16'h0020, 1'b1, 16'h1020, 4'd3}, // R5
      {4'hC, 1'b0, 8'h08, 16'h1000, 16'h0020, 1'b0, 16'h1000, 4'd3}, // R5
      {4'hD, 1'b0, 8'h02, 16'hFFF0, 16'h007F, 1'b1, 16'h006F, 4'd3}, // R5 R7
      {4'hE, 1'b0, 8'h00, 16'h1000, 16'h0010, 1'b1, 16'h1010, 4'd3}, // R6
      {4'hE, 1'b0, 8'h0E, 16'h1000, 16'h0010, 1'b0, 16'h1000, 4'd3}, // R6
      {4'hF, 1'b0, 8'h04, 16'h1000, 16'h0010, 1'b1, 16'h1010, 4'd3}, // R6
      {4'hF, 1'b0, 8'h08, 16'h1000, 16'h0010, 1'b1, 16'h1010, 4'd3}, // R6
      {4'hF, 1'b1, 8'h0A, 16'h1000, 16'h0010, 1'b0, 16'h1000, 4'd5}, // R6 R10
      {4'h7, 1'b0, 8'hF0, 16'h1000, 16'h0010, 1'b0, 16'h1000, 4'd3}, // R11
      {4'h6, 1'b0, 8'hFB, 16'h1000, 16'h0010, 1'b1, 16'h1010, 4'd3}  // R11
   };

   task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
      end
   endtask

   task automatic drive(input logic [3:0] s, input logic l, input logic [7:0] c,
                        input logic [15:0] p, input logic [15:0] d);
      cond_sel = s; long_form = l; ccr = c; pc_after = p; disp = d;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: outputs cleared while reset is held
      drive(4'h0, 1'b1, 8'h00, 16'h1234, 16'h0001);
      @(negedge clk);
      chk("R1", "taken", 32'(taken), 0);
      chk("R1", "next_pc", 32'(next_pc), 0);
      chk("R1", "cycles", 32'(cycles), 0);
      rst_n = 1'b1;

      // Table walk: each result due one edge after drive
      for (int i = 0; i < NV; i++) begin
         logic [65:0] v;
         v = VEC[i];
         drive(v[65:62], v[61], v[60:53], v[52:37], v[36:21]);
         @(negedge clk);
         chk($sformatf("vec%0d", i), "taken", 32'(taken), 32'(v[20]));
         chk($sformatf("vec%0d", i), "next_pc", 32'(next_pc), 32'(v[19:4]));
         chk($sformatf("vec%0d", i), "cycles", 32'(cycles), 32'(v[3:0]));
      end

      // R12: output holds the old result until the capturing edge
      drive(4'h0, 1'b1, 8'h00, 16'h3000, 16'h0100);
      @(negedge clk);
      chk("R12", "next_pc settled", 32'(next_pc), 32'h3100);
      drive(4'h1, 1'b0, 8'h00, 16'h4000, 16'h0010);
      @(posedge clk); #1;
      chk("R12", "next_pc after edge", 32'(next_pc), 32'h4000);
      drive(4'h0, 1'b0, 8'h00, 16'h5000, 16'h0010);
      @(negedge clk); #1;
      chk("R12", "next_pc before edge", 32'(next_pc), 32'h4000);
      chk("R12", "cycles before edge", 32'(cycles), 32'd3);
      @(negedge clk);
      chk("R12", "next_pc new", 32'(next_pc), 32'h5010);

      // R7: short form ignores upper displacement byte entirely
      drive(4'h0, 1'b0, 8'h00, 16'h8000, 16'hFF7F);
      @(negedge clk);
      chk("R7", "upper disp ignored", 32'(next_pc), 32'h807F);

      // R8: long form wraps above the top
      drive(4'h0, 1'b1, 8'h00, 16'hFFFF, 16'h0002);
      @(negedge clk);
      chk("R8", "long wrap", 32'(next_pc), 32'h0001);

      // R1: reset mid-run clears outputs again
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1", "taken after reset", 32'(taken), 0);
      chk("R1", "cycles after reset", 32'(cycles), 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule